// File: doc/BRIEF.md
# Repeating-Slice LFSR Operand Generator

This block produces the operand stimulus for a multiplier under built-in self-test. A Fibonacci linear-feedback shift register steps once per enabled cycle. The register's width, start value and feedback taps are all set by parameters. The register is not placed directly on the operands. Instead, two short slices of its state are each copied side by side until they fill the A and B operand buses.

Because of this copying, the full test is the same register sequence for any multiplier width. An 8x8, 16x16 or 32x32 array gets the same 255 patterns. Only the way the slices are spread over the wider buses changes.

A run works as follows. The test controller releases reset, or pulses the load strobe, which restarts the sequence at the seed. It then holds enable high until the done flag rises. When the pattern budget is used up, the register stops on its final state and the flag stays set. It stays set until the next load or reset.

Top module: `bist_operand_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register takes the seed (default 0x7B), the pattern count clears and `done` is low after that edge.
- R2: On an edge with `en` high, `load` low and `done` low, the register state s becomes {s[LFSR_W-2:0], f}. Here f is the XOR of every bit s[i] for which bit i of the tap mask is set. The default mask 0xB8 gives the polynomial x^8+x^6+x^5+x^4+1.
- R3: With the default taps, the state returns to the seed after exactly 255 steps and never before, and the all-zero state never occurs.
- R4: A seed parameter of zero is replaced by the value 1.
- R5: Operand bit `op_a[i]` equals state bit (i mod SLICE_W), and `op_b[i]` equals state bit (SLICE_W + i mod SLICE_W). The default SLICE_W is 4. This holds for any operand width, including one that is not a multiple of SLICE_W.
- R6: With `en` and `load` both low, the register state, and so both operands, stay unchanged.
- R7: `done` rises on the edge that completes the PATTERNS-th step (default 255). After that, `en` has no effect: the state and `done` hold.
- R8: A high `load` at an edge returns the state to the seed and clears the count and `done`. It does this whether or not `en` is high.
- R9: The number of steps before `done` is the same for every operand width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset to the seed |
| en | input | 1 | Advance the register by one pattern this cycle |
| load | input | 1 | Reload the seed and restart the pattern count |
| op_a | output | OPA_W | Operand A, low slice replicated |
| op_b | output | OPB_W | Operand B, upper slice replicated |
| done | output | 1 | Pattern budget reached; generator frozen |

## Verification
The sequence is first walked step by step against a bench model of the stated feedback rule. This separates a correct tap set and shift direction from a mirrored or mis-tapped register. A full uninterrupted run from the seed to `done` measures the period itself: any cycle shorter or longer than 255, or a visit to zero, is seen there. Idle gaps, a load issued while enable is high, and enable pulses after `done` each isolate one control path. A second instance with a zero seed, a 32-bit A bus and a 10-bit B bus shows the seed substitution, the slice copying into a width that is not a whole number of slices, and a pattern length that does not depend on width.

// File: rtl/bog_pkg.sv
// Shared definitions for the operand generator.
// Assumes: nothing beyond IEEE 1800-2017.
package bog_pkg;

    // Register action selected once per cycle by the top-level control.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } bog_act_e;

    // A zero start value would lock an XOR-feedback register; use 1 instead.
    function automatic logic [63:0] safe_seed(input logic [63:0] seed, input int unsigned width);
        logic [63:0] masked;
        masked = seed & ((64'd1 << width) - 64'd1);
        return (masked == 64'd0) ? 64'd1 : masked;
    endfunction

endpackage

// File: rtl/bog_lfsr.sv
// Fibonacci shift register: shifts toward the MSB and feeds the XOR of the
// tapped stages into bit 0. Reset and reload both go to the seed.
// Assumes: W >= 2; a zero seed is replaced by 1.
module bog_lfsr
    import bog_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter logic [63:0] SEED = 64'h7B,
    parameter logic [63:0] TAPS = 64'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bog_act_e     act,
    output logic [W-1:0] state_o
);

    localparam logic [W-1:0] SEED_OK  = W'(safe_seed(SEED, W));
    localparam logic [W-1:0] TAP_MASK = TAPS[W-1:0];

    logic [W-1:0] state_q;
    logic         feedback;

    // Mod-2 sum of the stages selected by the tap mask.
    always_comb begin
        feedback = ^(state_q & TAP_MASK);
    end

    // State register: reset or reload to the seed, otherwise shift or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED_OK;
        end else begin
            case (act)
                ACT_LOAD: state_q <= SEED_OK;
                ACT_STEP: state_q <= {state_q[W-2:0], feedback};
                default:  state_q <= state_q;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/bog_pattern_ctr.sv
// Counts register steps and raises done once the budget is reached.
// Assumes: PATTERNS >= 1; the caller stops stepping once done is high.
module bog_pattern_ctr
    import bog_pkg::*;
#(
    parameter int unsigned PATTERNS = 255
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bog_act_e act,
    output logic     done
);

    localparam int unsigned CW = $clog2(PATTERNS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PATTERNS);

    logic [CW-1:0] count_q;

    // Step counter: cleared by reset or reload, incremented on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            case (act)
                ACT_LOAD: count_q <= '0;
                ACT_STEP: count_q <= (count_q == LIMIT) ? count_q : count_q + 1'b1;
                default:  count_q <= count_q;
            endcase
        end
    end

    // Budget reached.
    always_comb begin
        done = (count_q == LIMIT);
    end

endmodule

// File: rtl/bog_replicate.sv
// Copies a SLICE_W-bit window of the source, starting at OFFSET, across
// OUT_W output bits. A final partial copy takes the low bits of the window.
// Assumes: OFFSET + SLICE_W <= SRC_W.
module bog_replicate #(
    parameter int unsigned SRC_W   = 8,
    parameter int unsigned SLICE_W = 4,
    parameter int unsigned OFFSET  = 0,
    parameter int unsigned OUT_W   = 16
) (
    input  logic [SRC_W-1:0] src,
    output logic [OUT_W-1:0] dst
);

    // One wire per output bit, chosen by its position within the slice.
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        assign dst[i] = src[OFFSET + (i % SLICE_W)];
    end

endmodule

// File: rtl/bist_operand_gen.sv
// Self-test operand source: an LFSR whose low and next slices are replicated
// across the A and B buses, plus a pattern budget that freezes the sequence.
// Assumes: LFSR_W >= 2*SLICE_W; TAPS give a maximal-length sequence.
module bist_operand_gen
    import bog_pkg::*;
#(
    parameter int unsigned LFSR_W   = 8,
    parameter logic [63:0] SEED     = 64'h7B,
    parameter logic [63:0] TAPS     = 64'hB8,
    parameter int unsigned SLICE_W  = 4,
    parameter int unsigned OPA_W    = 16,
    parameter int unsigned OPB_W    = 16,
    parameter int unsigned PATTERNS = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    output logic [OPA_W-1:0] op_a,
    output logic [OPB_W-1:0] op_b,
    output logic             done
);

    localparam int unsigned B_OFFSET = SLICE_W;

    bog_act_e          act;
    logic [LFSR_W-1:0] lfsr_q;

    // Action select: reload wins, then a step if the budget is not spent.
    always_comb begin
        if (load) begin
            act = ACT_LOAD;
        end else if (en && !done) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    bog_lfsr #(
        .W    (LFSR_W),
        .SEED (SEED),
        .TAPS (TAPS)
    ) lfsr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .state_o (lfsr_q)
    );

    bog_pattern_ctr #(
        .PATTERNS (PATTERNS)
    ) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .done  (done)
    );

    bog_replicate #(
        .SRC_W   (LFSR_W),
        .SLICE_W (SLICE_W),
        .OFFSET  (0),
        .OUT_W   (OPA_W)
    ) rep_a_i (
        .src (lfsr_q),
        .dst (op_a)
    );

    bog_replicate #(
        .SRC_W   (LFSR_W),
        .SLICE_W (SLICE_W),
        .OFFSET  (B_OFFSET),
        .OUT_W   (OPB_W)
    ) rep_b_i (
        .src (lfsr_q),
        .dst (op_b)
    );

endmodule

// File: rtl/bist_operand_gen_chk.sv
// Property checker for bist_operand_gen, attached with bind below.
// Assumes: the bound instance exposes its register state as lfsr_q.
module bist_operand_gen_chk
    import bog_pkg::*;
#(
    parameter int unsigned LFSR_W  = 8,
    parameter logic [63:0] SEED    = 64'h7B,
    parameter int unsigned SLICE_W = 4,
    parameter int unsigned OPA_W   = 16,
    parameter int unsigned OPB_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              load,
    input logic              done,
    input logic [OPA_W-1:0]  op_a,
    input logic [OPB_W-1:0]  op_b,
    input logic [LFSR_W-1:0] state
);

    localparam logic [LFSR_W-1:0] SEED_OK = LFSR_W'(safe_seed(SEED, LFSR_W));

    AST_RESET_SEED: assert property (@(posedge clk) !rst_n |=> (state == SEED_OK) && !done); // R1
    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !done) |=> state[LFSR_W-1:1] == $past(state[LFSR_W-2:0])); // R2
    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) state != '0); // R3
    AST_LANE_A_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        op_a[OPA_W-1] == state[(OPA_W-1) % SLICE_W]); // R5
    AST_LANE_B_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        op_b[OPB_W-1] == state[SLICE_W + ((OPB_W-1) % SLICE_W)]); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(state) && $stable(done)); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done && $stable(state)); // R7
    AST_LOAD_RESEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state == SEED_OK) && !done); // R8

endmodule

bind bist_operand_gen bist_operand_gen_chk #(
    .LFSR_W  (LFSR_W),
    .SEED    (SEED),
    .SLICE_W (SLICE_W),
    .OPA_W   (OPA_W),
    .OPB_W   (OPB_W)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .load  (load),
    .done  (done),
    .op_a  (op_a),
    .op_b  (op_b),
    .state (lfsr_q)
);

// File: tb/bist_operand_gen_tb_top.sv
// Directed bench: a default instance and a wide-bus, zero-seed instance,
// both driven by the same control inputs and compared to a bench model.
module bist_operand_gen_tb_top;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        en    = 1'b0;
    logic        load  = 1'b0;
    logic [15:0] op_a;
    logic [15:0] op_b;
    logic        done;
    logic [31:0] w_op_a;
    logic [9:0]  w_op_b;
    logic        w_done;

    int checks = 0;
    int fails  = 0;

    // Bench model of each instance: state and steps taken.
    logic [7:0] m_s;
    int         m_n;
    logic [7:0] w_s;
    int         w_n;

    always #2.5 clk = ~clk;

    bist_operand_gen dut_i (
        .clk (clk), .rst_n (rst_n), .en (en), .load (load),
        .op_a (op_a), .op_b (op_b), .done (done)
    );

    bist_operand_gen #(
        .SEED (64'h0), .OPA_W (32), .OPB_W (10)
    ) dut_w_i (
        .clk (clk), .rst_n (rst_n), .en (en), .load (load),
        .op_a (w_op_a), .op_b (w_op_b), .done (w_done)
    );

    // Next state from R2 with mask 0xB8.
    function automatic logic [7:0] nxt(input logic [7:0] s);
        return {s[6:0], ^(s & 8'hB8)};
    endfunction

    // Expected replicated bus from R5.
    function automatic logic [31:0] rep(input logic [7:0] s, input int off, input int w);
        logic [31:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = s[off + (i % 4)];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: update both models for the driven controls, then sample.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_s = 8'h7B; m_n = 0; w_s = 8'h01; w_n = 0;
        end else if (load) begin
            m_s = 8'h7B; m_n = 0; w_s = 8'h01; w_n = 0;
        end else if (en) begin
            if (m_n < 255) begin m_s = nxt(m_s); m_n++; end
            if (w_n < 255) begin w_s = nxt(w_s); w_n++; end
        end
        #1;
    endtask

    // Full comparison of both instances against the models.
    task automatic cmp_all(input string req);
        chk({op_b[3:0], op_a[3:0]} == m_s, req, {op_b[3:0], op_a[3:0]}, m_s);
        chk(op_a == rep(m_s, 0, 16) && op_b == rep(m_s, 4, 16), {req, "/R5"},
            {op_a, op_b}, {rep(m_s, 0, 16), rep(m_s, 4, 16)});
        chk(w_op_a == rep(w_s, 0, 32) && w_op_b == rep(w_s, 4, 10), {req, "/R5 wide"},
            {w_op_a, 22'd0, w_op_b}, {rep(w_s, 0, 32), 22'd0, rep(w_s, 4, 10)});
        chk(done == (m_n == 255) && w_done == (w_n == 255), {req, "/R7 done"},
            {done, w_done}, {m_n == 255, w_n == 255});
    endtask

    // R1, R4: reset state of both instances.
    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0; load = 1'b0;
        tick(); tick();
        chk({op_b[3:0], op_a[3:0]} == 8'h7B, "R1 seed", {op_b[3:0], op_a[3:0]}, 8'h7B);
        chk(done == 1'b0, "R1 done low", done, 0);
        chk({w_op_b[7:4], w_op_a[3:0]} == 8'h01, "R4 zero seed", {w_op_b[7:4], w_op_a[3:0]}, 8'h01);
        rst_n = 1'b1;
    endtask

    // R2, R5: twelve single steps compared against the model.
    task automatic t_steps();
        en = 1'b1;
        for (int k = 0; k < 12; k++) begin tick(); cmp_all("R2 step"); end
        en = 1'b0;
    endtask

    // R6: idle cycles leave everything unchanged.
    task automatic t_idle();
        logic [15:0] a0 = op_a;
        en = 1'b0; load = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick();
            chk(op_a == a0, "R6 hold", op_a, a0);
            cmp_all("R6");
        end
    endtask

    // R8: load with en high reseeds instead of stepping.
    task automatic t_load();
        en = 1'b1; tick(); tick();
        load = 1'b1; tick(); load = 1'b0; en = 1'b0;
        chk({op_b[3:0], op_a[3:0]} == 8'h7B, "R8 reload", {op_b[3:0], op_a[3:0]}, 8'h7B);
        chk(done == 1'b0, "R8 done cleared", done, 0);
        cmp_all("R8");
    endtask

    // R3, R7, R9: full run from the seed, then enable after done.
    task automatic t_period();
        int  first = 0;
        bit  zero_seen = 0;
        int  w_at = 0;
        en = 1'b1;
        for (int k = 1; k <= 260; k++) begin
            tick();
            if ({op_b[3:0], op_a[3:0]} == 8'h00) zero_seen = 1;
            if (first == 0 && {op_b[3:0], op_a[3:0]} == 8'h7B) first = k;
            if (w_at == 0 && w_done) w_at = k;
            if (k == 254) chk(!done, "R7 not early", done, 0);
            if (k == 255) begin
                chk(done, "R7 done at budget", done, 1);
                cmp_all("R3");
            end
        end
        chk(first == 255, "R3 period", first, 255);
        chk(!zero_seen, "R3 no zero", zero_seen, 0);
        chk(w_at == 255, "R9 wide length", w_at, 255);
        chk(done && {op_b[3:0], op_a[3:0]} == 8'h7B, "R7 frozen", {op_b[3:0], op_a[3:0]}, 8'h7B);
        cmp_all("R7");
        en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_steps();
        t_idle();
        t_load();
        t_period();
        t_load();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule